// File: doc/BRIEF.md
# Five-Level Space-Vector Sector and Dwell-Time Calculator

This block serves the modulator of a single-phase rectifier whose port voltage takes nine levels: zero and plus or minus one, two, three and four quarters of the DC-link voltage. Once per switching period the control loop presents a signed reference voltage, already normalised to the DC-link voltage, together with the length of the coming switching period in clock ticks. It raises a one-cycle start strobe. The block then finds which of eight sectors holds the reference, and so the two adjacent levels that bound it.

It returns the dwell time of each of the two levels as a tick count. The split obeys volt-second balance over the period. Because adjacent levels are exactly a quarter of the DC-link voltage apart, the split reduces to a shift and one multiply, and no divider is needed.

The results are registered. They change only in the cycle that raises the valid pulse, so a downstream gate sequencer always reads a matched sector and dwell pair.

Top module: `svm_dwell_calc`

## Requirements
- R1: With the reference as a signed fixed-point number carrying FRAC fraction bits (1.0 equals the DC-link voltage), a non-negative reference of magnitude m selects sector code 0 (sector I, levels +4/+3) for m ≥ 3/4, code 1 (sector II, +3/+2) for 1/2 ≤ m < 3/4, code 2 (sector III, +2/+1) for 1/4 ≤ m < 1/2 and code 3 (sector IV, +1/0) for m < 1/4.
- R2: A negative reference selects the mirror sector: code 4 (sector V, 0/−1) nearest zero, then codes 5 and 6, and code 7 (sector VIII, −3/−4) for the most negative values, so that bit 2 of the sector code equals the sign of the reference.
- R3: A reference lying exactly on a quarter-step threshold goes to the sector of larger magnitude.
- R4: The dwell of the larger-magnitude level is dwellX = floor(4·(m − mLow)·Ts), where mLow is the magnitude of the smaller bounding level and Ts is the sampled period length. This equals floor(r·Ts / 2^(FRAC−2)), where r is the magnitude's remainder within its quarter step.
- R5: The dwell of the smaller-magnitude level is dwellY = Ts − dwellX, so the two always add up to the sampled period.
- R6: A reference of magnitude 1.0 or more, including the most negative code, is clamped to sector code 0 or 7 with dwellX = Ts and dwellY = 0.
- R7: The reference and period are sampled at the clock edge where the start strobe is high. The results appear, and the valid output is high, exactly one cycle after that edge. Valid stays high for one cycle per strobe, and strobes on consecutive cycles each produce their own result.
- R8: Between valid pulses the sector and dwell outputs hold their values, whatever the reference and period inputs do while no strobe is applied.
- R9: After reset the sector code is 3, both dwell counts are 0 and valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodStart | input | 1 | Start-of-period strobe; samples refIn and periodTicks |
| refIn | input | REF_W | Signed reference normalised to the DC-link voltage, FRAC fraction bits |
| periodTicks | input | CNT_W | Switching period length in clock ticks |
| sectorOut | output | 3 | Sector code 0..7 for sectors I..VIII |
| dwellX | output | CNT_W | Ticks for the larger-magnitude bounding level |
| dwellY | output | CNT_W | Ticks for the smaller-magnitude bounding level |
| dwellValid | output | 1 | One-cycle pulse when new results are presented |

## Verification
The hardest cases to reach from the ports are the sector edges. They are the exact quarter-step thresholds, the code one below each threshold, and the most negative input code, whose magnitude cannot be written in the input width and must still be clamped. A plain sweep rarely hits these values. The stimulus therefore adds every threshold and its neighbour on both signs, zero and both full-scale codes to a fine sweep of the whole input range, and repeats the set at several period lengths down to a single-digit tick count.

// File: rtl/svm_dwell_pkg.sv
package svm_dwell_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch reference and period
    logic publish;  // load result registers
  } dwellCtrl_t;

  localparam logic [2:0] SECTOR_RESET = 3'd3;
endpackage

// File: rtl/svm_dwell_ctrl.sv
module svm_dwell_ctrl
  import svm_dwell_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       periodStart,
  output dwellCtrl_t ctrl,
  output logic       validOut
);
  logic publishQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      publishQ <= 1'b0;
      validOut <= 1'b0;
    end else begin
      publishQ <= periodStart;
      validOut <= publishQ;
    end
  end

  always_comb begin
    ctrl.capture = periodStart;
    ctrl.publish = publishQ;
  end
endmodule

// File: rtl/svm_dwell_path.sv
module svm_dwell_path
  import svm_dwell_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int FRAC  = 14,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dwellCtrl_t              ctrl,
  input  logic signed [REF_W-1:0] refIn,
  input  logic [CNT_W-1:0]        periodTicks,
  output logic [2:0]              sectorOut,
  output logic [CNT_W-1:0]        dwellX,
  output logic [CNT_W-1:0]        dwellY
);
  localparam int REM_W  = FRAC - 2;
  localparam int PROD_W = REM_W + CNT_W;
  localparam logic [REF_W-1:0] FULL_SCALE = REF_W'(1) << FRAC;

  // stage 1: sampled sign, magnitude and period
  logic             refNeg;
  logic [REF_W-1:0] refMag;
  logic [CNT_W-1:0] tsReg;
  logic [REF_W-1:0] magNext;

  assign magNext = refIn[REF_W-1] ? $unsigned(-refIn) : $unsigned(refIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refNeg <= 1'b0;
      refMag <= '0;
      tsReg  <= '0;
    end else if (ctrl.capture) begin
      refNeg <= refIn[REF_W-1];
      refMag <= magNext;
      tsReg  <= periodTicks;
    end
  end

  // stage 2: sector decode and dwell split
  logic             overRange;
  logic [1:0]       level;
  logic [REM_W-1:0] remain;
  logic [PROD_W-1:0] prod;
  logic [2:0]       sectorNext;
  logic [CNT_W-1:0] txNext;
  logic [CNT_W-1:0] tyNext;

  always_comb begin
    overRange = (refMag >= FULL_SCALE);
    level     = refMag[FRAC-1:FRAC-2];
    remain    = refMag[REM_W-1:0];
    prod      = {{CNT_W{1'b0}}, remain} * {{REM_W{1'b0}}, tsReg};
    if (overRange) begin
      sectorNext = refNeg ? 3'd7 : 3'd0;
      txNext     = tsReg;
    end else begin
      sectorNext = refNeg ? {1'b1, level} : {1'b0, ~level};
      txNext     = CNT_W'(prod >> REM_W);
    end
    tyNext = tsReg - txNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sectorOut <= SECTOR_RESET;
      dwellX    <= '0;
      dwellY    <= '0;
    end else if (ctrl.publish) begin
      sectorOut <= sectorNext;
      dwellX    <= txNext;
      dwellY    <= tyNext;
    end
  end
endmodule

// File: rtl/svm_dwell_calc.sv
module svm_dwell_calc
  import svm_dwell_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int FRAC  = 14,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    periodStart,
  input  logic signed [REF_W-1:0] refIn,
  input  logic [CNT_W-1:0]        periodTicks,
  output logic [2:0]              sectorOut,
  output logic [CNT_W-1:0]        dwellX,
  output logic [CNT_W-1:0]        dwellY,
  output logic                    dwellValid
);
  dwellCtrl_t ctrl;

  svm_dwell_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .periodStart(periodStart),
    .ctrl       (ctrl),
    .validOut   (dwellValid)
  );

  svm_dwell_path #(.REF_W(REF_W), .FRAC(FRAC), .CNT_W(CNT_W)) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .refIn      (refIn),
    .periodTicks(periodTicks),
    .sectorOut  (sectorOut),
    .dwellX     (dwellX),
    .dwellY     (dwellY)
  );
endmodule

// File: rtl/svm_dwell_chk.sv
module svm_dwell_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             periodStart,
  input logic             refSign,
  input logic [CNT_W-1:0] periodTicks,
  input logic [2:0]       sectorOut,
  input logic [CNT_W-1:0] dwellX,
  input logic [CNT_W-1:0] dwellY,
  input logic             dwellValid
);
  assert_dwell_sum_R5: assert property (@(posedge clk) disable iff (!rstN)
    dwellValid |-> ({1'b0, dwellX} + {1'b0, dwellY}) == {1'b0, $past(periodTicks, 2)});

  assert_dwell_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    dwellValid |-> dwellX <= $past(periodTicks, 2));

  assert_sign_sector_R2: assert property (@(posedge clk) disable iff (!rstN)
    dwellValid |-> sectorOut[2] == $past(refSign, 2));

  assert_valid_after_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> ##1 dwellValid);

  assert_valid_has_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    dwellValid |-> $past(periodStart, 2));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !dwellValid |-> ($stable(sectorOut) && $stable(dwellX) && $stable(dwellY)));
endmodule

bind svm_dwell_calc svm_dwell_chk #(.CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .periodStart(periodStart),
  .refSign    (refIn[REF_W-1]),
  .periodTicks(periodTicks),
  .sectorOut  (sectorOut),
  .dwellX     (dwellX),
  .dwellY     (dwellY),
  .dwellValid (dwellValid)
);

// File: tb/test_svm_dwell_calc.sv
module test_svm_dwell_calc;
  localparam int REF_W = 16;
  localparam int FRAC  = 14;
  localparam int CNT_W = 16;
  localparam int ONE   = 1 << FRAC;
  localparam int QTR   = ONE / 4;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    periodStart = 1'b0;
  logic signed [REF_W-1:0] refIn = '0;
  logic [CNT_W-1:0]        periodTicks = '0;
  logic [2:0]              sectorOut;
  logic [CNT_W-1:0]        dwellX;
  logic [CNT_W-1:0]        dwellY;
  logic                    dwellValid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  svm_dwell_calc #(.REF_W(REF_W), .FRAC(FRAC), .CNT_W(CNT_W)) i_svm_dwell_calc (
    .clk(clk), .rstN(rstN), .periodStart(periodStart), .refIn(refIn),
    .periodTicks(periodTicks), .sectorOut(sectorOut), .dwellX(dwellX),
    .dwellY(dwellY), .dwellValid(dwellValid));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run exceeded cycle limit");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected results from the requirements
  function automatic void model(input int r, input int ts,
                                output int sec, output int tx, output int ty);
    int mag, k, rem;
    bit neg;
    neg = (r < 0);
    mag = neg ? -r : r;
    if (mag >= ONE) begin          // R6 clamp
      sec = neg ? 7 : 0;
      tx  = ts;
    end else begin
      k   = mag / QTR;             // R1, R3: floor puts thresholds upward
      rem = mag % QTR;
      sec = neg ? 4 + k : 3 - k;   // R2 mirror
      tx  = int'((longint'(rem) * ts) / QTR);  // R4
    end
    ty = ts - tx;                  // R5
  endfunction

  function automatic string reqFor(input int r);
    int mag;
    mag = (r < 0) ? -r : r;
    if (mag >= ONE) return "R6";
    if (mag % QTR == 0 && mag != 0) return "R3";
    return (r < 0) ? "R2" : "R1";
  endfunction

  task automatic runOne(input int r, input int ts);
    int sec, tx, ty;
    string rq;
    model(r, ts, sec, tx, ty);
    rq = reqFor(r);
    refIn = REF_W'(r);
    periodTicks = CNT_W'(ts);
    periodStart = 1'b1;
    @(negedge clk);
    periodStart = 1'b0;
    check("R7 no early valid", dwellValid, 0);
    @(negedge clk);
    check("R7 valid", dwellValid, 1);
    check({rq, " sector"}, sectorOut, sec);
    check({rq == "R6" ? "R6" : "R4", " dwellX"}, dwellX, tx);
    check({rq == "R6" ? "R6" : "R5", " dwellY"}, dwellY, ty);
    // disturb inputs without a strobe
    refIn = REF_W'(r ^ 16'h5a5a);
    periodTicks = CNT_W'(ts + 123);
    @(negedge clk);
    check("R7 single pulse", dwellValid, 0);
    check("R8 hold sector", sectorOut, sec);
    check("R8 hold dwellX", dwellX, tx);
    check("R8 hold dwellY", dwellY, ty);
  endtask

  initial begin
    int periods [4] = '{20000, 1000, 7, 65535};
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 sector", sectorOut, 3);
    check("R9 dwellX", dwellX, 0);
    check("R9 dwellY", dwellY, 0);
    check("R9 valid", dwellValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    foreach (periods[p]) begin
      // boundaries: thresholds, neighbours, zero, full scale
      for (int k = 0; k <= 4; k++) begin
        runOne(k * QTR, periods[p]);
        runOne(-k * QTR, periods[p]);
        if (k > 0) begin
          runOne(k * QTR - 1, periods[p]);
          runOne(-(k * QTR - 1), periods[p]);
        end
      end
      runOne(-1, periods[p]);
      runOne(32767, periods[p]);
      runOne(-32768, periods[p]);
      // sweep of the whole input range
      for (int v = -32768; v <= 32767; v += 257) runOne(v, periods[p]);
    end

    // R7 back-to-back strobes give two results on consecutive cycles
    begin
      int s1, x1, y1, s2, x2, y2;
      model(9000, 5000, s1, x1, y1);
      model(-2500, 3000, s2, x2, y2);
      refIn = 16'sd9000; periodTicks = 16'd5000; periodStart = 1'b1;
      @(negedge clk);
      refIn = -16'sd2500; periodTicks = 16'd3000;
      @(negedge clk);
      periodStart = 1'b0;
      check("R7 first of pair valid", dwellValid, 1);
      check("R7 first of pair sector", sectorOut, s1);
      check("R7 first of pair dwellX", dwellX, x1);
      @(negedge clk);
      check("R7 second of pair valid", dwellValid, 1);
      check("R7 second of pair sector", sectorOut, s2);
      check("R7 second of pair dwellY", dwellY, y2);
      @(negedge clk);
      check("R7 pair ends", dwellValid, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule